// File: doc/BRIEF.md
# In-Band Interrupt Payload Sequencer

This block runs the data phase of an in-band interrupt raised by an I3C target. Software loads payload bytes into a small transmit FIFO and pulses a start input. The sequencer then asks the bus engine to send the request header. Each refusal by the controller triggers a new attempt, up to a programmable retry limit. Once the controller accepts the request, the sequencer first sends the programmed mandatory data byte. It then sends FIFO bytes in order, one per byte handshake with the serializer.

Each byte carries the value of the following T-bit. A high value means more data follows. A low value is the End-of-Data mark. The sequencer ends the transfer for one of three reasons: the FIFO has run dry, the maximum payload size has been reached, or the controller has cut the transfer short at a T-bit. It records the outcome in sticky flags.

The block also holds the maximum payload size register. A SETMRL command path or firmware can load it, and it is presented for GETMRL replies.

Top module: `ibi_payload_seq`

## Requirements
- R1: After `hdr_ack`, the first byte presented is `mdb` unchanged: the group identifier stays in bits [7:5] and the specific identifier in bits [4:0]. Its `byte_more` is 1 exactly when the FIFO holds at least one byte.
- R2: Payload bytes follow the mandatory byte in FIFO write order. Bytes left behind by an earlier transfer are sent first by the next one. A presented byte and its `byte_more` stay stable until `byte_done`.
- R3: When no further FIFO byte is available, the byte being sent carries `byte_more`=0. After its `byte_done`, `flag_done` and `flag_comp` are set, `flag_abort` stays clear, and `ibi_req` falls.
- R4: With `mrl`=N>0, the Nth payload byte carries `byte_more`=0 even if the FIFO holds more data. The mandatory byte does not count toward N. The flags are set as in R3, and `fifo_not_empty` stays 1.
- R5: A `byte_done` with `ctl_abort`=1 on a byte whose `byte_more` is 1 ends the transfer. It sets `flag_abort`, `flag_done` and `flag_comp`. No further byte is presented, and unsent FIFO bytes remain.
- R6: `setmrl_wr` loads `mrl` from `setmrl_val`, and `fw_mrl_wr` loads it from `fw_mrl_val`. When both are asserted in the same cycle, the firmware value wins. The reset value of `mrl` is 0.
- R7: With `mrl`=0 the payload length is unlimited, and every FIFO byte is sent.
- R8: `ibi_req` rises the cycle after `ibi_go` in idle and stays high until the transfer or the retry sequence ends. `ibi_go` has no effect while `ibi_req` is high. In idle, neither `hdr_try` nor `byte_valid` is asserted.
- R9: Each `hdr_nack` makes the block re-attempt the request. When the NACK count reaches a nonzero `retry_lim`, the block sets `flag_err`, drops `ibi_req`, and sends no byte. With `retry_lim`=0, attempts continue without limit.
- R10: All flags are sticky. Writing 1 to a bit of `flag_clr` clears that flag: bit 0 `flag_done`, bit 1 `flag_comp`, bit 2 `flag_abort`, bit 3 `flag_err`. A set in the same cycle wins over a clear.
- R11: A FIFO write while `fifo_full` is 1 is dropped. Reset leaves the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ibi_go | input | 1 | Start pulse for an in-band interrupt |
| ibi_req | output | 1 | Interrupt in progress |
| mdb | input | 8 | Mandatory data byte |
| retry_lim | input | 8 | NACK limit, 0 = unlimited |
| hdr_try | output | 1 | Request header attempt to the bus engine |
| hdr_ack | input | 1 | Controller accepted the request |
| hdr_nack | input | 1 | Controller refused the request |
| byte_valid | output | 1 | Byte offered to the serializer |
| byte_data | output | 8 | Byte value |
| byte_more | output | 1 | T-bit value: 1 more data, 0 End-of-Data |
| byte_done | input | 1 | Serializer finished the byte and T-bit |
| ctl_abort | input | 1 | Controller pulled the T-bit low |
| fifo_wr | input | 1 | Payload FIFO write |
| fifo_wdata | input | 8 | Payload FIFO write data |
| fifo_full | output | 1 | FIFO full |
| fifo_not_empty | output | 1 | FIFO holds data |
| setmrl_wr | input | 1 | Command-path size write |
| setmrl_val | input | 8 | Command-path size value |
| fw_mrl_wr | input | 1 | Firmware size write |
| fw_mrl_val | input | 8 | Firmware size value |
| mrl | output | 8 | Maximum payload size, 0 = unlimited |
| flag_clr | input | 4 | Write-one-to-clear for the flags |
| flag_done | output | 1 | IBI done |
| flag_comp | output | 1 | Transfer complete |
| flag_abort | output | 1 | Controller abort |
| flag_err | output | 1 | Retry limit reached |

## Verification
The properties assume that the serializer pulses `byte_done` only while `byte_valid` is high, and that `hdr_ack` and `hdr_nack` come only while `hdr_try` is high and never together. They also assume that `mrl` is not rewritten during a transfer. The directed tasks keep to these conditions. Each handshake task waits for the matching output before it drives a one-cycle response. Size writes happen only while `ibi_req` is low, with the single exception of an ignored `ibi_go` pulse.

// File: rtl/ibi_payload_seq.sv
module ibi_payload_seq #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ibi_go,
  output logic       ibi_req,
  input  logic [7:0] mdb,
  input  logic [7:0] retry_lim,
  output logic       hdr_try,
  input  logic       hdr_ack,
  input  logic       hdr_nack,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_more,
  input  logic       byte_done,
  input  logic       ctl_abort,
  input  logic       fifo_wr,
  input  logic [7:0] fifo_wdata,
  output logic       fifo_full,
  output logic       fifo_not_empty,
  input  logic       setmrl_wr,
  input  logic [7:0] setmrl_val,
  input  logic       fw_mrl_wr,
  input  logic [7:0] fw_mrl_val,
  output logic [7:0] mrl,
  input  logic [3:0] flag_clr,
  output logic       flag_done,
  output logic       flag_comp,
  output logic       flag_abort,
  output logic       flag_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_MDB, S_LOAD, S_PAY} st_t;
  st_t st;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] fcnt;
  logic [7:0]    out_q, pay_cnt, rcnt;
  logic          more_q;
  logic          set_end, set_abort, set_err;

  wire push = fifo_wr && !fifo_full;
  wire pop  = (st == S_PAY) && byte_done;
  wire xfer = ((st == S_MDB) || (st == S_PAY)) && byte_done;
  wire next_more = (fcnt >= CW'(2)) &&
                   ((mrl == 8'd0) || (({1'b0, pay_cnt} + 9'd1) < {1'b0, mrl}));

  assign fifo_full      = (fcnt == CW'(DEPTH));
  assign fifo_not_empty = (fcnt != '0);
  assign ibi_req        = (st != S_IDLE);
  assign hdr_try        = (st == S_REQ);
  assign byte_valid     = (st == S_MDB) || (st == S_PAY);
  assign byte_data      = out_q;
  assign byte_more      = more_q;

  always_ff @(posedge clk) if (push) mem[wp] <= fifo_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; fcnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   fcnt <= fcnt + CW'(1);
        2'b01:   fcnt <= fcnt - CW'(1);
        default: fcnt <= fcnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mrl <= 8'd0;
    else if (fw_mrl_wr) mrl <= fw_mrl_val;
    else if (setmrl_wr) mrl <= setmrl_val;
  end

  always_comb begin
    set_end   = xfer && (!more_q || ctl_abort);
    set_abort = xfer && more_q && ctl_abort;
    set_err   = (st == S_REQ) && !hdr_ack && hdr_nack &&
                (retry_lim != 8'd0) && ((rcnt + 8'd1) == retry_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; out_q <= 8'd0; more_q <= 1'b0; pay_cnt <= 8'd0; rcnt <= 8'd0;
    end else begin
      case (st)
        S_IDLE: if (ibi_go) begin
          st   <= S_REQ;
          rcnt <= 8'd0;
        end
        S_REQ: begin
          if (hdr_ack) begin
            st      <= S_MDB;
            out_q   <= mdb;
            more_q  <= fifo_not_empty;
            pay_cnt <= 8'd0;
          end else if (hdr_nack) begin
            if (set_err) st <= S_IDLE;
            else         rcnt <= rcnt + 8'd1;
          end
        end
        S_MDB: if (byte_done) st <= set_end ? S_IDLE : S_LOAD;
        S_LOAD: begin
          st     <= S_PAY;
          out_q  <= mem[rp];
          more_q <= next_more;
        end
        S_PAY: if (byte_done) begin
          pay_cnt <= pay_cnt + 8'd1;
          st      <= set_end ? S_IDLE : S_LOAD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_done <= 1'b0; flag_comp <= 1'b0; flag_abort <= 1'b0; flag_err <= 1'b0;
    end else begin
      flag_done  <= (flag_done  & ~flag_clr[0]) | set_end;
      flag_comp  <= (flag_comp  & ~flag_clr[1]) | set_end;
      flag_abort <= (flag_abort & ~flag_clr[2]) | set_abort;
      flag_err   <= (flag_err   & ~flag_clr[3]) | set_err;
    end
  end
endmodule

// File: rtl/ibi_payload_seq_chk.sv
module ibi_payload_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ibi_req,
  input logic [7:0] mdb,
  input logic       hdr_try,
  input logic       hdr_ack,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       byte_more,
  input logic       byte_done,
  input logic       ctl_abort,
  input logic       fifo_full,
  input logic       setmrl_wr,
  input logic [7:0] setmrl_val,
  input logic       fw_mrl_wr,
  input logic [7:0] fw_mrl_val,
  input logic [7:0] mrl,
  input logic       flag_done,
  input logic       flag_comp,
  input logic       flag_abort
);
  logic       mdb_phase;
  logic [7:0] pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdb_phase <= 1'b0; pc <= 8'd0;
    end else if (hdr_try && hdr_ack) begin
      mdb_phase <= 1'b1; pc <= 8'd0;
    end else if (byte_valid && byte_done) begin
      if (mdb_phase) mdb_phase <= 1'b0;
      else           pc <= pc + 8'd1;
    end
  end

  AST_MDB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_try && hdr_ack |=> byte_valid && byte_data == $past(mdb)); // R1
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_done |=> byte_valid && $stable(byte_data) && $stable(byte_more)); // R2
  AST_EOD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && byte_done && !byte_more |=> !ibi_req && flag_done && flag_comp); // R3
  AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !mdb_phase && mrl != 8'd0 && ({1'b0, pc} + 9'd1) == {1'b0, mrl} |-> !byte_more); // R4
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && byte_done && byte_more && ctl_abort |=> flag_abort && flag_done && flag_comp && !ibi_req); // R5
  AST_FW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    fw_mrl_wr |=> mrl == $past(fw_mrl_val)); // R6
  AST_SETMRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    setmrl_wr && !fw_mrl_wr |=> mrl == $past(setmrl_val)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ibi_req |-> !byte_valid && !hdr_try); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && !(byte_valid && byte_done) |=> fifo_full); // R11
endmodule

bind ibi_payload_seq ibi_payload_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ibi_req(ibi_req), .mdb(mdb), .hdr_try(hdr_try),
  .hdr_ack(hdr_ack), .byte_valid(byte_valid), .byte_data(byte_data),
  .byte_more(byte_more), .byte_done(byte_done), .ctl_abort(ctl_abort),
  .fifo_full(fifo_full), .setmrl_wr(setmrl_wr), .setmrl_val(setmrl_val),
  .fw_mrl_wr(fw_mrl_wr), .fw_mrl_val(fw_mrl_val), .mrl(mrl),
  .flag_done(flag_done), .flag_comp(flag_comp), .flag_abort(flag_abort)
);

// File: tb/test_ibi_payload_seq.sv
module test_ibi_payload_seq;
  logic clk = 0, rst_n = 0;
  logic ibi_go = 0, hdr_ack = 0, hdr_nack = 0, byte_done = 0, ctl_abort = 0;
  logic fifo_wr = 0, setmrl_wr = 0, fw_mrl_wr = 0;
  logic [7:0] mdb = 8'hA3, retry_lim = 0, fifo_wdata = 0, setmrl_val = 0, fw_mrl_val = 0;
  logic [3:0] flag_clr = 0;
  logic ibi_req, hdr_try, byte_valid, byte_more, fifo_full, fifo_not_empty;
  logic flag_done, flag_comp, flag_abort, flag_err;
  logic [7:0] byte_data, mrl;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ibi_payload_seq #(.DEPTH(4)) i_ibi_payload_seq (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    fifo_wr = 1; fifo_wdata = d; tick(); fifo_wr = 0;
  endtask

  task automatic start();
    ibi_go = 1; tick(); ibi_go = 0;
  endtask

  task automatic wait_try();
    for (int i = 0; i < 50 && !hdr_try; i++) tick();
  endtask

  task automatic ack();
    wait_try(); hdr_ack = 1; tick(); hdr_ack = 0;
  endtask

  task automatic nack();
    wait_try(); hdr_nack = 1; tick(); hdr_nack = 0;
  endtask

  task automatic take(input bit ab, input string r, input int ed, input int em);
    for (int i = 0; i < 50 && !byte_valid; i++) tick();
    chk({r, " data"}, byte_data, ed);
    chk({r, " more"}, byte_more, em);
    byte_done = 1; ctl_abort = ab; tick(); byte_done = 0; ctl_abort = 0;
  endtask

  task automatic clear_all();
    flag_clr = 4'hF; tick(); flag_clr = 0;
  endtask

  task automatic fw_size(input logic [7:0] v);
    fw_mrl_wr = 1; fw_mrl_val = v; tick(); fw_mrl_wr = 0;
  endtask

  task automatic t_reset();
    chk("R8 reset ibi_req", ibi_req, 0);
    chk("R8 reset valid", byte_valid, 0);
    chk("R10 reset flags", {flag_done, flag_comp, flag_abort, flag_err}, 0);
    chk("R6 reset mrl", mrl, 0);
    chk("R11 reset fifo", fifo_not_empty, 0);
  endtask

  task automatic t_empty();
    start();
    chk("R8 req up", ibi_req, 1);
    ack();
    take(0, "R1 mdb alone", 8'hA3, 0);
    chk("R3 flags", {flag_done, flag_comp, flag_abort}, 3'b110);
    chk("R8 req down", ibi_req, 0);
    clear_all();
  endtask

  task automatic t_stream();
    push(8'h11); push(8'h22); push(8'h33);
    start(); ack();
    take(0, "R1 mdb", 8'hA3, 1);
    ibi_go = 1; tick(); ibi_go = 0;
    take(0, "R7 b0", 8'h11, 1);
    take(0, "R2 b1", 8'h22, 1);
    take(0, "R3 last", 8'h33, 0);
    chk("R3 flags", {flag_done, flag_comp, flag_abort}, 3'b110);
    repeat (3) tick();
    chk("R8 go ignored while busy", {ibi_req, hdr_try}, 0);
    clear_all();
  endtask

  task automatic t_limit();
    setmrl_wr = 1; setmrl_val = 8'd2; tick(); setmrl_wr = 0;
    chk("R6 setmrl", mrl, 2);
    push(8'h40); push(8'h41); push(8'h42); push(8'h43);
    start(); ack();
    take(0, "R4 mdb", 8'hA3, 1);
    take(0, "R4 p0", 8'h40, 1);
    take(0, "R4 p1 limit", 8'h41, 0);
    chk("R4 flags", {flag_done, flag_comp, flag_abort}, 3'b110);
    chk("R4 fifo kept", fifo_not_empty, 1);
    clear_all();
    fw_size(8'd1);
    start(); ack();
    take(0, "R4 mdb size1", 8'hA3, 1);
    take(0, "R4 size1 p0", 8'h42, 0);
    fw_size(8'd0);
    clear_all();
    start(); ack();
    take(0, "R2 mdb leftover", 8'hA3, 1);
    take(0, "R2 leftover", 8'h43, 0);
    chk("R2 fifo drained", fifo_not_empty, 0);
    clear_all();
  endtask

  task automatic t_abort();
    push(8'h50); push(8'h51); push(8'h52);
    start(); ack();
    take(0, "R5 mdb", 8'hA3, 1);
    take(1, "R5 p0", 8'h50, 1);
    chk("R5 flags", {flag_done, flag_comp, flag_abort}, 3'b111);
    chk("R5 req down", ibi_req, 0);
    repeat (4) tick();
    chk("R5 no byte", byte_valid, 0);
    chk("R5 fifo kept", fifo_not_empty, 1);
    clear_all();
    start(); ack();
    take(0, "R5 drain mdb", 8'hA3, 1);
    take(0, "R5 drain0", 8'h51, 1);
    take(0, "R5 drain1", 8'h52, 0);
    chk("R5 no abort flag", flag_abort, 0);
    clear_all();
  endtask

  task automatic t_mrl();
    setmrl_wr = 1; setmrl_val = 8'd7; fw_mrl_wr = 1; fw_mrl_val = 8'd9; tick();
    setmrl_wr = 0; fw_mrl_wr = 0;
    chk("R6 fw wins", mrl, 9);
    setmrl_wr = 1; setmrl_val = 8'd5; tick(); setmrl_wr = 0;
    chk("R6 setmrl alone", mrl, 5);
    fw_size(8'd0);
    chk("R6 fw alone", mrl, 0);
  endtask

  task automatic t_retry();
    retry_lim = 8'd2;
    start(); nack();
    chk("R9 retrying", {ibi_req, hdr_try}, 2'b11);
    nack();
    chk("R9 gave up", ibi_req, 0);
    chk("R9 err flag", flag_err, 1);
    chk("R9 no byte", byte_valid, 0);
    flag_clr = 4'b0001; tick(); flag_clr = 0;
    chk("R10 err sticky", flag_err, 1);
    clear_all();
    chk("R10 err cleared", flag_err, 0);
    retry_lim = 8'd0;
    start();
    repeat (6) nack();
    chk("R9 unlimited", {ibi_req, flag_err}, 2'b10);
    ack();
    take(0, "R9 mdb after retries", 8'hA3, 0);
  endtask

  task automatic t_clear();
    flag_clr = 4'b0001; tick(); flag_clr = 0;
    chk("R10 done cleared", flag_done, 0);
    chk("R10 comp sticky", flag_comp, 1);
    clear_all();
    chk("R10 all cleared", {flag_done, flag_comp}, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 5; i++) push(8'h60 + 8'(i));
    chk("R11 full", fifo_full, 1);
    start(); ack();
    take(0, "R11 mdb", 8'hA3, 1);
    for (int i = 0; i < 3; i++) take(0, "R11 body", 8'h60 + i, 1);
    take(0, "R11 last kept", 8'h63, 0);
    chk("R11 extra dropped", fifo_not_empty, 0);
    clear_all();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_empty();
    t_stream();
    t_limit();
    t_abort();
    t_mrl();
    t_retry();
    t_clear();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule